// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

An eight-pin general-purpose I/O port controlled through three byte-wide registers on a simple register bus: a drive-level register, a digital-enable register and a drive-type register. Each pin runs in one of three modes. In analog mode it is fully disconnected on the digital side. In open-drain mode it only pulls low. In push-pull mode it drives both levels. The drive-type setting has no effect on a pin in analog mode.

Per-pin outputs control a pad: drive value, output enable, weak pull-up enable and digital receiver enable. The pad input comes back through a two-flop synchronizer. A read at the drive-level address returns the synchronized pin levels, not the stored bits. Analog pins read as zero. The other two registers read back exactly as written. The register bus needs one cycle for a write. Reads are combinational from the current address.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the drive-level register holds all ones, the digital-enable register all ones and the drive-type register all zeros. Every pin is therefore open-drain released: enable 0, pull-up 1, receiver 1, drive value 0.
- R2: A write with `sfr_we_i` high at address 0xF4 (digital enable) or 0xA7 (drive type) updates that register on the same clock edge. A read at that address returns the stored byte.
- R3: A digital pin (digital-enable bit 1) whose drive-level bit is 0 has output enable 1, drive value 0 and pull-up 0.
- R4: A digital pin with drive-level bit 1 and drive-type bit 1 (push-pull) has output enable 1, drive value 1 and pull-up 1.
- R5: A digital pin with drive-level bit 1 and drive-type bit 0 (open-drain) has output enable 0, drive value 0 and pull-up 1.
- R6: A pin whose digital-enable bit is 0 (analog) has output enable, pull-up, receiver enable and drive value all 0.
- R7: For an analog pin, changing its drive-type bit leaves all of its pad outputs unchanged.
- R8: A read at address 0xB0 returns the pin input level for each digital pin, delayed by two clock edges through the synchronizer, and 0 for each analog pin. The stored drive-level bits do not appear in this value.
- R9: A read at any address other than 0xB0, 0xF4 or 0xA7 returns 0x00. A write to such an address changes no register.
- R10: Every digital pin has its receiver enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | Register address |
| sfr_we_i | input | 1 | Write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for the current address |
| pin_in_i | input | 8 | Raw pad input levels |
| pin_out_o | output | 8 | Pad drive value |
| pin_oe_o | output | 8 | Pad output enable |
| pin_pu_o | output | 8 | Weak pull-up enable |
| pin_rx_en_o | output | 8 | Digital receiver enable |

## Verification
The assertions assume three things about the inputs. The write strobe and address are stable around each clock edge. The bus holds at most one write per cycle. The pad input may change at any time, because only its synchronized copy feeds any checked relation. The stimulus changes bus inputs one time unit after a rising edge. It changes pin levels only between transactions and waits three edges before it reads them back. The properties relate register state to pad outputs within the same cycle, so they stay valid across every mode change the stimulus makes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 8'hB0;
  localparam logic [ADDR_W-1:0] ADDR_DIGEN = 8'hF4;
  localparam logic [ADDR_W-1:0] ADDR_DTYPE = 8'hA7;

  typedef enum logic [1:0] {
    MODE_ANALOG,
    MODE_OPEN_DRAIN,
    MODE_PUSH_PULL
  } pin_mode_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [PIN_W-1:0]  wdata_i,
  output logic [PIN_W-1:0]  level_o,
  output logic [PIN_W-1:0]  digen_o,
  output logic [PIN_W-1:0]  dtype_o
);
  localparam logic [PIN_W-1:0] LEVEL_RST = '1;
  localparam logic [PIN_W-1:0] DIGEN_RST = '1;
  localparam logic [PIN_W-1:0] DTYPE_RST = '0;

  logic [PIN_W-1:0] level_q, digen_q, dtype_q;
  logic hit_level, hit_digen, hit_dtype;

  assign hit_level = we_i && (addr_i == ADDR_LEVEL);
  assign hit_digen = we_i && (addr_i == ADDR_DIGEN);
  assign hit_dtype = we_i && (addr_i == ADDR_DTYPE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= LEVEL_RST;
      digen_q <= DIGEN_RST;
      dtype_q <= DTYPE_RST;
    end else begin
      if (hit_level) level_q <= wdata_i;
      if (hit_digen) digen_q <= wdata_i;
      if (hit_dtype) dtype_q <= wdata_i;
    end
  end

  assign level_o = level_q;
  assign digen_o = digen_q;
  assign dtype_o = dtype_q;

  a_r2_digen_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIGEN) |=> (digen_o == $past(wdata_i)));

  a_r2_dtype_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DTYPE) |=> (dtype_o == $past(wdata_i)));

  a_r9_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != ADDR_LEVEL && addr_i != ADDR_DIGEN && addr_i != ADDR_DTYPE)
    |=> ($stable(level_o) && $stable(digen_o) && $stable(dtype_o)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic [PIN_W-1:0] level_i,
  input  logic [PIN_W-1:0] digen_i,
  input  logic [PIN_W-1:0] dtype_i,
  output logic [PIN_W-1:0] out_o,
  output logic [PIN_W-1:0] oe_o,
  output logic [PIN_W-1:0] pu_o,
  output logic [PIN_W-1:0] rx_en_o
);
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    pin_mode_e mode;

    always_comb begin
      if (!digen_i[p])     mode = MODE_ANALOG;
      else if (dtype_i[p]) mode = MODE_PUSH_PULL;
      else                 mode = MODE_OPEN_DRAIN;
    end

    always_comb begin
      out_o[p]   = 1'b0;
      oe_o[p]    = 1'b0;
      pu_o[p]    = 1'b0;
      rx_en_o[p] = 1'b0;
      unique case (mode)
        MODE_ANALOG: ;
        MODE_OPEN_DRAIN: begin
          rx_en_o[p] = 1'b1;
          oe_o[p]    = !level_i[p];
          pu_o[p]    = level_i[p];
        end
        MODE_PUSH_PULL: begin
          rx_en_o[p] = 1'b1;
          oe_o[p]    = 1'b1;
          out_o[p]   = level_i[p];
          pu_o[p]    = level_i[p];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]  pin_sync_i,
  input  logic [PIN_W-1:0]  rx_en_i,
  input  logic [PIN_W-1:0]  digen_i,
  input  logic [PIN_W-1:0]  dtype_i,
  output logic [PIN_W-1:0]  rdata_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_LEVEL: rdata_o = pin_sync_i & rx_en_i;  // receiver off reads 0
      ADDR_DIGEN: rdata_o = digen_i;
      ADDR_DTYPE: rdata_o = dtype_i;
      default:    rdata_o = '0;
    endcase
  end

  always_comb begin
    if (addr_i != ADDR_LEVEL && addr_i != ADDR_DIGEN && addr_i != ADDR_DTYPE)
      a_r9_unmapped_zero: assert (rdata_o == '0);
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [PIN_W-1:0]  sfr_wdata_i,
  output logic [PIN_W-1:0]  sfr_rdata_o,
  input  logic [PIN_W-1:0]  pin_in_i,
  output logic [PIN_W-1:0]  pin_out_o,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic [PIN_W-1:0]  pin_pu_o,
  output logic [PIN_W-1:0]  pin_rx_en_o
);
  logic [PIN_W-1:0] level, digen, dtype, pin_sync;

  gpio_cfg_regs #(.PIN_W(PIN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (sfr_addr_i),
    .we_i    (sfr_we_i),
    .wdata_i (sfr_wdata_i),
    .level_o (level),
    .digen_o (digen),
    .dtype_o (dtype)
  );

  gpio_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_sync)
  );

  gpio_pin_ctrl #(.PIN_W(PIN_W)) u_pins (
    .level_i (level),
    .digen_i (digen),
    .dtype_i (dtype),
    .out_o   (pin_out_o),
    .oe_o    (pin_oe_o),
    .pu_o    (pin_pu_o),
    .rx_en_o (pin_rx_en_o)
  );

  gpio_rd_mux #(.PIN_W(PIN_W)) u_rd (
    .addr_i     (sfr_addr_i),
    .pin_sync_i (pin_sync),
    .rx_en_i    (pin_rx_en_o),
    .digen_i    (digen),
    .dtype_i    (dtype),
    .rdata_o    (sfr_rdata_o)
  );

  a_r3_drive_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((digen & ~level & ~(pin_oe_o & ~pin_out_o & ~pin_pu_o)) == '0));

  a_r4_push_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((digen & dtype & level & ~(pin_oe_o & pin_out_o & pin_pu_o)) == '0));

  a_r5_open_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((digen & ~dtype & level & (pin_oe_o | pin_out_o | ~pin_pu_o)) == '0));

  a_r6_analog_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~digen & (pin_oe_o | pin_pu_o | pin_rx_en_o | pin_out_o)) == '0));

  a_r8_analog_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == ADDR_LEVEL) |-> ((sfr_rdata_o & ~digen) == '0));

  a_r10_rx_digital: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((digen & ~pin_rx_en_o) == '0));
endmodule

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam logic [7:0] A_LVL = 8'hB0;
  localparam logic [7:0] A_DEN = 8'hF4;
  localparam logic [7:0] A_DTY = 8'hA7;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pin_in, p_out, p_oe, p_pu, p_rx;
  logic       rd_valid = 1'b0;
  int         checks = 0;
  int         fails = 0;
  sb_item_t   sb_q[$];

  always #2 clk = ~clk;

  gpio_port_bank uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sfr_addr_i  (addr),
    .sfr_we_i    (we),
    .sfr_wdata_i (wdata),
    .sfr_rdata_o (rdata),
    .pin_in_i    (pin_in),
    .pin_out_o   (p_out),
    .pin_oe_o    (p_oe),
    .pin_pu_o    (p_pu),
    .pin_rx_en_o (p_rx)
  );

  // Monitor: compare read data mid-cycle against scoreboard
  always @(negedge clk) begin
    if (rd_valid && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s read actual=%02h expected=%02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    addr = a;
    sb_q.push_back(it);
    rd_valid = 1'b1;
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  // Pad expectations taken from R3..R6, R10
  task automatic chk_pads(input logic [7:0] l, input logic [7:0] d, input logic [7:0] t,
                          input string tag);
    @(negedge clk);
    chk(p_oe,  d & (~l | t), {tag, " oe"});
    chk(p_out, d & l & t,    {tag, " out"});
    chk(p_pu,  d & l,        {tag, " pu"});
    chk(p_rx,  d,            {tag, " rx"});
  endtask

  task automatic run_all();
    pin_in = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_pads(8'hFF, 8'hFF, 8'h00, "R1");
    rd(A_DEN, 8'hFF, "R1 digen");
    rd(A_DTY, 8'h00, "R1 dtype");

    // R2 write/readback
    wr(A_DEN, 8'h3C); rd(A_DEN, 8'h3C, "R2 digen");
    wr(A_DTY, 8'hC3); rd(A_DTY, 8'hC3, "R2 dtype");

    // R3/R4/R5 all digital
    wr(A_DEN, 8'hFF);
    wr(A_DTY, 8'h0F);
    wr(A_LVL, 8'h33);
    chk_pads(8'h33, 8'hFF, 8'h0F, "R3 R4 R5 R10 mixed");
    wr(A_LVL, 8'h00);
    chk_pads(8'h00, 8'hFF, 8'h0F, "R3 all low");
    wr(A_LVL, 8'hFF);
    chk_pads(8'hFF, 8'hFF, 8'h0F, "R4 R5 all high");

    // R6 analog on upper nibble
    wr(A_DEN, 8'h0F);
    chk_pads(8'hFF, 8'h0F, 8'h0F, "R6 analog nibble");

    // R7 drive type flip on analog pins leaves pads
    wr(A_DTY, 8'hFF);
    chk_pads(8'hFF, 8'h0F, 8'h0F, "R7 dtype ignored");
    wr(A_DTY, 8'h0F);

    // R8 latch address reads synced pins, not stored value
    wr(A_LVL, 8'h00);
    wr(A_DEN, 8'hF0);
    pin_in = 8'hA5;
    repeat (3) @(posedge clk);
    rd(A_LVL, 8'hA0, "R8 pins masked by analog");
    wr(A_DEN, 8'hFF);
    rd(A_LVL, 8'hA5, "R8 pins all digital");
    wr(A_LVL, 8'h5A);
    rd(A_LVL, 8'hA5, "R8 not stored bits");

    // R8 two-edge latency
    @(posedge clk); #1;
    addr = A_LVL; pin_in = 8'h3C;
    @(posedge clk); #1;
    @(negedge clk); chk(rdata, 8'hA5, "R8 after one edge");
    @(posedge clk); #1;
    @(negedge clk); chk(rdata, 8'h3C, "R8 after two edges");

    // R9 unmapped
    rd(8'h00, 8'h00, "R9 read 00");
    rd(8'hB1, 8'h00, "R9 read B1");
    wr(8'h55, 8'h00);
    wr(8'hF5, 8'h00);
    rd(A_DEN, 8'hFF, "R9 digen unchanged");
    rd(A_DTY, 8'h0F, "R9 dtype unchanged");
    chk_pads(8'h5A, 8'hFF, 8'h0F, "R9 level unchanged");
    repeat (2) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule